// File: doc/BRIEF.md
# Erase and Program Sequencer for a Byte-Wide High-Voltage Flash Memory

This block acts as an external programmer for a byte-wide, many-times-programmable memory that is erased and written with a high programming supply and a high voltage on one address pin. A single `start` pulse launches a whole-array job. In erase-only mode the block erases the array electrically and then reads every byte back, expecting all ones. In program mode the block always erases and verifies first. It then writes the array one byte at a time, using a single chip-enable pulse per byte with no retries, and finally reads every byte back against the original image.

Image bytes come from a simple request/acknowledge port. The block raises `img_req` with `addr` as the image address and waits for `img_ack`. Every setup, hold, pulse, recovery and read-access delay is a parameter counted in clock cycles. The top address is also a parameter, so the whole sequence can run on a small array. The first read mismatch ends the job, and the block reports pass or fail together with the failing address.

Top module: `mtp_prog_seq`

## Requirements
- R1: After reset and while idle, the outputs are: `ce_n`=1, `oe_n`=1, `a9_hv`=0, `vpp_en`=0, `busy`=0, `done`=0, `pass`=0 and `img_req`=0.
- R2: The erase runs in four phases, each lasting exactly its parameter in cycles:
  - T_SU cycles with `a9_hv` and `vpp_en` high and `ce_n`/`oe_n` high;
  - T_ERASE cycles with `ce_n` low;
  - T_HD cycles with `ce_n` high and both supplies still on;
  - T_REC cycles with both supplies off.
  Throughout the erase, `addr` is 0.
- R3: After the erase, addresses 0 to LAST_ADDR are read in ascending order. Each read holds `ce_n`=`oe_n`=0 for T_ACC cycles, and `rdata` is sampled in the last of those cycles and compared with all ones.
- R4: Program mode (`mode_prog`=1) always performs the R2 erase and the R3 verify first. A failed erase verify ends the job without any programming.
- R5: Programming performs the following steps:
  - It holds `vpp_en` high for T_SU cycles at address 0.
  - For each address, it requests the image byte (`img_req` high until `img_ack`).
  - It then drives that byte on `wdata` for T_SU cycles with `ce_n` high, pulses `ce_n` low for T_PGM cycles, and holds for T_HD cycles.
  - It waits max(1, T_CYC-1-T_SU-T_PGM-T_HD) gap cycles.
  - After the last byte it turns the supply off for T_HD cycles.
- R6: After programming, each address is re-fetched from the image port while `ce_n`=`oe_n`=0. It is then read for T_ACC cycles and compared with the fetched byte.
- R7: The job ends at the first mismatch, with `pass`=0 and `fail_addr` set to that address. If every byte matches, it ends with `pass`=1. `done` is a one-cycle pulse with `busy` low, and the block is idle on the next cycle.
- R8: `start` and `mode_prog` are ignored while `busy` is high. The mode is captured at the cycle `start` is accepted.
- R9: `a9_hv` is never high without `vpp_en`. `oe_n` is never low while either high-voltage enable is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a job while idle |
| mode_prog | input | 1 | 0: erase and verify; 1: erase, verify, program, verify |
| img_ack | input | 1 | Image byte on `img_data` is valid |
| img_data | input | DATA_W | Image byte for address `addr` |
| rdata | input | DATA_W | Data read back from the memory |
| img_req | output | 1 | Request for the image byte at `addr` |
| ce_n | output | 1 | Chip enable to the memory, active low |
| oe_n | output | 1 | Output enable to the memory, active low |
| a9_hv | output | 1 | Enable for the high voltage on the erase-select address pin |
| vpp_en | output | 1 | Enable for the programming supply |
| addr | output | ADDR_W | Memory and image address |
| wdata | output | DATA_W | Byte to program |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| pass | output | 1 | Result of the last job |
| fail_addr | output | ADDR_W | First failing address of the last job |

## Verification
A wrong state or a wrong timer count shows up at the pins in the very cycle it happens. A phase that is one cycle short or long shifts an edge of `ce_n`, `a9_hv` or `vpp_en`. A wrong address step shows on `addr` at the next read or fetch. The bench therefore compares every output on every cycle against a per-cycle pin trace built from the requirements. A wrongly latched expected byte or a wrong compare stays hidden until the verify read of that address. It then appears as an early or missing `done` and a wrong `pass`/`fail_addr`. Device faults (an erase-resistant bit, an unprogrammable byte) are injected so that both verify paths and the failing address are exercised.

// File: rtl/mtp_seq_pkg.sv
package mtp_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_E_SU, S_E_PULSE, S_E_HOLD, S_E_REC,
    S_V_FETCH, S_V_READ,
    S_P_VPP, S_P_FETCH, S_P_SU, S_P_PULSE, S_P_HOLD, S_P_GAP, S_P_VOFF,
    S_DONE
  } seq_state_e;

  function automatic int dmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // pad after hold so that a byte (fetch + setup + pulse + hold + gap) spans T_CYC
  function automatic int byte_gap(input int cyc, input int su, input int pw, input int hd);
    int r;
    r = cyc - 1 - su - pw - hd;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
  parameter int AW   = 4,
  parameter int LAST = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (clr) addr_q <= '0;
    else if (inc) addr_q <= addr_q + 1'b1;
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == AW'(LAST));
endmodule

// File: rtl/mtp_prog_seq.sv
module mtp_prog_seq
  import mtp_seq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 11,
  parameter int T_SU      = 2,
  parameter int T_HD      = 2,
  parameter int T_ERASE   = 20,
  parameter int T_PGM     = 5,
  parameter int T_CYC     = 12,
  parameter int T_REC     = 3,
  parameter int T_ACC     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_prog,
  input  logic              img_ack,
  input  logic [DATA_W-1:0] img_data,
  input  logic [DATA_W-1:0] rdata,
  output logic              img_req,
  output logic              ce_n,
  output logic              oe_n,
  output logic              a9_hv,
  output logic              vpp_en,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int GAP  = byte_gap(T_CYC, T_SU, T_PGM, T_HD);
  localparam int MAXD = dmax(dmax(dmax(T_SU, T_HD), dmax(T_ERASE, T_PGM)),
                             dmax(dmax(T_REC, T_ACC), GAP));
  localparam int TW   = $clog2(MAXD + 1);

  seq_state_e st_q, st_d;
  logic prog_q, vphase_q, pass_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] fail_addr_q;

  // named internal events
  logic t_zero, at_last, addr_clr, addr_inc, rd_sample, mism;
  logic go, latch, pass_set, fail_set, vphase_set, t_load;
  logic [DATA_W-1:0] exp_byte;

  function automatic logic [TW-1:0] dur_m1(input seq_state_e s);
    case (s)
      S_E_SU, S_P_SU, S_P_VPP: return TW'(T_SU - 1);
      S_E_PULSE:               return TW'(T_ERASE - 1);
      S_E_HOLD, S_P_HOLD,
      S_P_VOFF:                return TW'(T_HD - 1);
      S_E_REC:                 return TW'(T_REC - 1);
      S_V_READ:                return TW'(T_ACC - 1);
      S_P_PULSE:               return TW'(T_PGM - 1);
      S_P_GAP:                 return TW'(GAP - 1);
      default:                 return '0;
    endcase
  endfunction

  seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(dur_m1(st_d)), .zero(t_zero)
  );

  seq_addr_ctr #(.AW(ADDR_W), .LAST(LAST_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc), .addr(addr), .at_last(at_last)
  );

  assign exp_byte = vphase_q ? data_q : {DATA_W{1'b1}};
  assign mism     = (rdata != exp_byte);
  assign t_load   = (st_d != st_q) || addr_inc;

  always_comb begin
    st_d = st_q;
    addr_clr = 1'b0; addr_inc = 1'b0; rd_sample = 1'b0; go = 1'b0;
    latch = 1'b0; pass_set = 1'b0; fail_set = 1'b0; vphase_set = 1'b0;
    case (st_q)
      S_IDLE:    if (start) begin st_d = S_E_SU; addr_clr = 1'b1; go = 1'b1; end
      S_E_SU:    if (t_zero) st_d = S_E_PULSE;
      S_E_PULSE: if (t_zero) st_d = S_E_HOLD;
      S_E_HOLD:  if (t_zero) st_d = S_E_REC;
      S_E_REC:   if (t_zero) st_d = S_V_READ;
      S_V_FETCH: if (img_ack) begin latch = 1'b1; st_d = S_V_READ; end
      S_V_READ: if (t_zero) begin
        rd_sample = 1'b1;
        if (mism) begin
          fail_set = 1'b1; st_d = S_DONE;
        end else if (at_last) begin
          if (!vphase_q && prog_q) begin addr_clr = 1'b1; st_d = S_P_VPP; end
          else begin pass_set = 1'b1; st_d = S_DONE; end
        end else begin
          addr_inc = 1'b1;
          st_d = vphase_q ? S_V_FETCH : S_V_READ;
        end
      end
      S_P_VPP:   if (t_zero) st_d = S_P_FETCH;
      S_P_FETCH: if (img_ack) begin latch = 1'b1; st_d = S_P_SU; end
      S_P_SU:    if (t_zero) st_d = S_P_PULSE;
      S_P_PULSE: if (t_zero) st_d = S_P_HOLD;
      S_P_HOLD:  if (t_zero) st_d = S_P_GAP;
      S_P_GAP: if (t_zero) begin
        if (at_last) st_d = S_P_VOFF;
        else begin addr_inc = 1'b1; st_d = S_P_FETCH; end
      end
      S_P_VOFF: if (t_zero) begin addr_clr = 1'b1; vphase_set = 1'b1; st_d = S_V_FETCH; end
      S_DONE:   st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; prog_q <= 1'b0; vphase_q <= 1'b0; pass_q <= 1'b0;
      data_q <= '0; fail_addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (go) begin
        prog_q <= mode_prog; vphase_q <= 1'b0; pass_q <= 1'b0; fail_addr_q <= '0;
      end
      if (vphase_set) vphase_q <= 1'b1;
      if (latch)      data_q <= img_data;
      if (pass_set)   pass_q <= 1'b1;
      if (fail_set)   fail_addr_q <= addr;
    end
  end

  assign ce_n    = !(st_q inside {S_E_PULSE, S_P_PULSE, S_V_FETCH, S_V_READ});
  assign oe_n    = !(st_q inside {S_V_FETCH, S_V_READ});
  assign a9_hv   = st_q inside {S_E_SU, S_E_PULSE, S_E_HOLD};
  assign vpp_en  = st_q inside {S_E_SU, S_E_PULSE, S_E_HOLD, S_P_VPP, S_P_FETCH,
                                S_P_SU, S_P_PULSE, S_P_HOLD, S_P_GAP};
  assign img_req = st_q inside {S_P_FETCH, S_V_FETCH};
  assign busy    = !(st_q inside {S_IDLE, S_DONE});
  assign done    = (st_q == S_DONE);
  assign wdata   = data_q;
  assign pass    = pass_q;
  assign fail_addr = fail_addr_q;

endmodule

// File: rtl/mtp_prog_seq_chk.sv
module mtp_prog_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              a9_hv,
  input logic              vpp_en,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_sample
);
  // R9
  a9_needs_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a9_hv |-> vpp_en);
  // R9
  read_low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!vpp_en && !a9_hv));
  // R5
  pulse_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> ($stable(addr) && $stable(wdata)));
  // R2
  erase_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ce_n) && a9_hv) |-> ($past(a9_hv) && $past(vpp_en)));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  sample_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |-> (!ce_n && !oe_n && busy));
endmodule

bind mtp_prog_seq mtp_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mtp_prog_seq.sv
module tb_mtp_prog_seq;
  localparam int AW = 4, DW = 8, LAST = 11;
  localparam int SU = 2, HD = 2, ER = 20, PG = 5, CY = 12, RC = 3, AC = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_prog = 1'b0;
  logic img_ack, img_req, ce_n, oe_n, a9_hv, vpp_en, busy, done, pass;
  logic [DW-1:0] img_data, rdata, wdata;
  logic [AW-1:0] addr, fail_addr;

  always #10 clk = ~clk;

  mtp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST), .T_SU(SU), .T_HD(HD),
    .T_ERASE(ER), .T_PGM(PG), .T_CYC(CY), .T_REC(RC), .T_ACC(AC)) dut (.*);

  // device and image models
  logic [7:0] mem [0:LAST];
  logic [7:0] img [0:LAST];
  int stuck_a = -1, weak_a = -1, lat = 0, wcnt = 0;

  assign rdata    = (!ce_n && !oe_n && !vpp_en && !a9_hv && int'(addr) <= LAST) ? mem[addr] : 8'h00;
  assign img_ack  = img_req && (wcnt >= lat);
  assign img_data = (int'(addr) <= LAST) ? img[addr] : 8'h00;

  always @(posedge clk) begin
    if (img_req && !img_ack) wcnt <= wcnt + 1; else wcnt <= 0;
    if (!ce_n && oe_n && vpp_en && a9_hv) begin
      for (int i = 0; i <= LAST; i++) mem[i] = 8'hFF;
      if (stuck_a >= 0) mem[stuck_a][0] = 1'b0;
    end else if (!ce_n && oe_n && vpp_en && !a9_hv && int'(addr) <= LAST && int'(addr) != weak_a)
      mem[addr] = mem[addr] & wdata;
  end

  int checks = 0, fails = 0, cyc = 0;
  logic [6:0] q_pin[$];
  int q_addr[$], q_w[$];
  string q_tag[$];
  bit exp_pass;
  int exp_fa;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R7 watchdog: actual no done, expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic push(int n, bit c, bit o, bit a9, bit v, bit b, bit d, bit r,
                      int a, int w, string tag);
    for (int i = 0; i < n; i++) begin
      q_pin.push_back({c, o, a9, v, b, d, r});
      q_addr.push_back(a); q_w.push_back(w); q_tag.push_back(tag);
    end
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // build the expected pin trace from the requirements
  task automatic build(bit prog);
    logic [7:0] dev [0:LAST];
    int gap = CY - 1 - SU - PG - HD;
    if (gap < 1) gap = 1;
    q_pin.delete(); q_addr.delete(); q_w.delete(); q_tag.delete();
    exp_pass = 1'b1; exp_fa = 0;
    push(SU, 1, 1, 1, 1, 1, 0, 0, 0, -1, "R2");
    push(ER, 0, 1, 1, 1, 1, 0, 0, 0, -1, "R2");
    push(HD, 1, 1, 1, 1, 1, 0, 0, 0, -1, "R2");
    push(RC, 1, 1, 0, 0, 1, 0, 0, 0, -1, "R2");
    for (int a = 0; a <= LAST; a++) begin
      dev[a] = (a == stuck_a) ? 8'hFE : 8'hFF;
      push(AC, 0, 0, 0, 0, 1, 0, 0, a, -1, prog ? "R4" : "R3");
      if (dev[a] != 8'hFF && exp_pass) begin exp_pass = 1'b0; exp_fa = a; break; end
    end
    if (prog && exp_pass) begin
      push(SU, 1, 1, 0, 1, 1, 0, 0, 0, -1, "R5");
      for (int a = 0; a <= LAST; a++) begin
        push(lat + 1, 1, 1, 0, 1, 1, 0, 1, a, -1, "R5");
        push(SU, 1, 1, 0, 1, 1, 0, 0, a, img[a], "R5");
        push(PG, 0, 1, 0, 1, 1, 0, 0, a, img[a], "R5");
        push(HD, 1, 1, 0, 1, 1, 0, 0, a, img[a], "R5");
        push(gap, 1, 1, 0, 1, 1, 0, 0, a, -1, "R5");
        if (a != weak_a) dev[a] = img[a];
      end
      push(HD, 1, 1, 0, 0, 1, 0, 0, LAST, -1, "R5");
      for (int a = 0; a <= LAST; a++) begin
        push(lat + 1, 0, 0, 0, 0, 1, 0, 1, a, -1, "R6");
        push(AC, 0, 0, 0, 0, 1, 0, 0, a, -1, "R6");
        if (dev[a] != img[a]) begin exp_pass = 1'b0; exp_fa = a; break; end
      end
    end
    push(1, 1, 1, 0, 0, 0, 1, 0, -1, -1, "R7");
    push(1, 1, 1, 0, 0, 0, 0, 0, -1, -1, "R7");
  endtask

  task automatic run(bit prog, int poke_at);
    int step = 0;
    for (int i = 0; i <= LAST; i++) mem[i] = 8'(i * 29 + 3);
    build(prog);
    @(negedge clk); start = 1'b1; mode_prog = prog;
    @(negedge clk); start = 1'b0;
    while (q_pin.size() > 0) begin
      logic [6:0] ep = q_pin.pop_front();
      int ea = q_addr.pop_front(), ew = q_w.pop_front();
      string tg = q_tag.pop_front();
      chk({ce_n, oe_n, a9_hv, vpp_en, busy, done, img_req} == ep, tg,
          "pins{ce,oe,a9,vpp,busy,done,req}", {ce_n, oe_n, a9_hv, vpp_en, busy, done, img_req}, ep);
      if (ea >= 0) chk(int'(addr) == ea, tg, "addr", addr, ea);
      if (ew >= 0) chk(int'(wdata) == ew, tg, "wdata", wdata, ew);
      chk((!a9_hv || vpp_en) && (oe_n || (!vpp_en && !a9_hv)), "R9", "hv safety",
          {a9_hv, vpp_en, oe_n}, 0);
      if (ep[1]) begin
        chk(pass == exp_pass, "R7", "pass", pass, exp_pass);
        if (!exp_pass) chk(int'(fail_addr) == exp_fa, "R7", "fail_addr", fail_addr, exp_fa);
      end
      step++;
      // R8: start and mode toggled mid-job must not change the trace
      if (poke_at > 0 && step == poke_at) begin start = 1'b1; mode_prog = ~prog; end
      else begin start = 1'b0; mode_prog = prog; end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i <= LAST; i++) img[i] = 8'(i * 53 + 17);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ce_n, oe_n, a9_hv, vpp_en, busy, done, pass, img_req} == 8'b1100_0000, "R1",
        "reset outputs", {ce_n, oe_n, a9_hv, vpp_en, busy, done, pass, img_req}, 8'hC0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && ce_n && !vpp_en, "R1", "idle after reset", {busy, ce_n, vpp_en}, 3'b010);
    // R2 R3 clean erase-only
    stuck_a = -1; weak_a = -1; lat = 0; run(1'b0, 0);
    // R3 R7 erase-resistant bit at 5
    stuck_a = 5; run(1'b0, 0);
    // R4 R5 R6 full program, immediate image port
    stuck_a = -1; img[3] = 8'hFF; run(1'b1, 0);
    // R5 R8 slow image port and start/mode pokes mid-job
    lat = 2; for (int i = 0; i <= LAST; i++) img[i] = 8'(i * 71 + 5);
    run(1'b1, 10);
    run(1'b1, 150);
    // R4 erase fails at address 0: no programming
    stuck_a = 0; lat = 1; run(1'b1, 0);
    // R6 R7 last byte cannot be programmed
    stuck_a = -1; weak_a = LAST; img[LAST] = 8'h5A; lat = 0; run(1'b1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule